// File: doc/BRIEF.md
# Barrel-Shared Peripheral Processor Context Rotator

This block lets one execution engine stand in for ten small 12-bit processors. Each processor's register set (an 18-bit accumulator that also serves as an address, a 12-bit program counter, a 12-bit operand register, a 7-bit instruction key and a step counter) lives in one stage of a circular shift ring. The ring advances one stage on every base clock. Only the context at the head stage is worked on, and its updated version re-enters at the tail. Each processor therefore gets one minor cycle, which is one access to its private 4K x 12 word memory, once every ten base clocks.

Instructions take one, two or five of a processor's own minor cycles. A context that is partway through an instruction carries its step count around the ring and resumes on its next visit. The decoder covers a small subset: load a 6-bit constant, load its 18-bit complement, branch when the accumulator is negative, and a five-step indirect replace-add. A deadstart input sends every processor back to word zero of its memory.

Top module: `pp_barrel`

## Requirements
- R1: After reset every context has all registers and its step counter at zero, and slot 0 is at the head. The first cycle after reset is therefore a read by slot 0 of address 0.
- R2: Exactly one context is at the head each base clock. The slot number on `mem_slot` counts 0, 1, ... N_CTX-1 and then wraps to 0, so each context is served once every N_CTX clocks.
- R3: On a fetch visit (step 0) the context reads its own memory at its program counter. Bits 11:6 of the word are the opcode and bits 5:0 are the field d. The program counter advances by one, modulo 4096.
- R4: Opcode octal 14 sets the accumulator to d zero-extended to 18 bits and completes in that single visit, so the next visit fetches the next word.
- R5: Opcode octal 15 sets the accumulator to the 18-bit bitwise complement of d zero-extended. It completes in one visit.
- R6: Opcode octal 07 takes two visits. The second visit makes no memory access. If accumulator bit 17 is set, the program counter becomes d. Otherwise execution continues with the next word.
- R7: Opcode octal 56 takes five visits. Visit 2 reads a pointer from address d. Visit 3 reads the operand at that pointer and adds it to the accumulator modulo 2^18. Visit 4 writes accumulator bits 11:0 to the pointer address. Visit 5 writes accumulator bits 17:12, zero-extended, to pointer+1.
- R8: A multi-visit instruction keeps its progress in its own context between visits. Contexts in different instructions or steps do not affect one another. The step count never exceeds 4.
- R9: While deadstart is high no memory access is made, and every context's program counter and step counter are cleared; the other registers keep their values. An instruction that is interrupted this way performs no further writes. The first visit after deadstart falls is a fetch from address 0.
- R10: Any other opcode is a one-visit no-operation that only advances the program counter.
- R11: `mem_we` is high only together with `mem_req`, and only on visits 4 and 5 of opcode octal 56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base (barrel) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deadstart | input | 1 | Restart all contexts at word 0 |
| mem_req | output | 1 | Head slot accesses its memory this cycle |
| mem_we | output | 1 | Access is a write |
| mem_slot | output | $clog2(N_CTX) | Index of the context (and memory) at the head |
| mem_addr | output | 12 | Word address in the selected memory |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data from the selected memory, same cycle |

## Verification
The hardest case to reach is several contexts sitting at different steps of different multi-visit instructions at the same moment. Only that case shows whether progress really travels with each context instead of being held in the shared engine. The bench produces it by loading even slots with the five-visit replace-add program and odd slots with a branch program, so that neighbouring ring positions alternate between pointer reads, quiet branch visits and write-backs. It then checks per-slot results at the ports and per-slot memories. A second case is deadstart arriving while every slot is mid-way through the replace-add. There the bench checks that no partial write-back survives and that each slot adds exactly once after the restart.

// File: rtl/pp_barrel_pkg.sv
package pp_barrel_pkg;

  localparam int WORD_W = 12;
  localparam int ACC_W  = 18;
  localparam int OPC_W  = 6;
  localparam int FLD_W  = WORD_W - OPC_W;
  localparam int KEY_W  = OPC_W + 1;
  localparam int STEP_W = 3;
  localparam int HI_W   = ACC_W - WORD_W;

  localparam logic [OPC_W-1:0] OPC_MJN = 6'o07;
  localparam logic [OPC_W-1:0] OPC_LDN = 6'o14;
  localparam logic [OPC_W-1:0] OPC_LCN = 6'o15;
  localparam logic [OPC_W-1:0] OPC_RAW = 6'o56;

  localparam logic [STEP_W-1:0] ST_FETCH = 3'd0;
  localparam logic [STEP_W-1:0] ST_PTR   = 3'd1;
  localparam logic [STEP_W-1:0] ST_OPND  = 3'd2;
  localparam logic [STEP_W-1:0] ST_WLO   = 3'd3;
  localparam logic [STEP_W-1:0] ST_WHI   = 3'd4;

  typedef struct packed {
    logic [ACC_W-1:0]  acc;
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] opr;
    logic [KEY_W-1:0]  key;   // {multi-visit flag, opcode}
    logic [STEP_W-1:0] step;
  } ctx_t;

  localparam ctx_t CTX_RESET = '0;

  function automatic logic [OPC_W-1:0] fn_opcode(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OPC_W];
  endfunction

  function automatic logic [FLD_W-1:0] fn_field(input logic [WORD_W-1:0] w);
    return w[FLD_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] fn_near_const(input logic [FLD_W-1:0] d);
    return {{(ACC_W-FLD_W){1'b0}}, d};
  endfunction

  function automatic logic [ACC_W-1:0] fn_comp_const(input logic [FLD_W-1:0] d);
    return ~fn_near_const(d);
  endfunction

  function automatic logic [ACC_W-1:0] fn_acc_add(input logic [ACC_W-1:0] a,
                                                  input logic [WORD_W-1:0] w);
    return a + {{(ACC_W-WORD_W){1'b0}}, w};
  endfunction

  function automatic logic [WORD_W-1:0] fn_acc_hi(input logic [ACC_W-1:0] a);
    return {{(WORD_W-HI_W){1'b0}}, a[ACC_W-1:WORD_W]};
  endfunction

  function automatic logic fn_is_neg(input logic [ACC_W-1:0] a);
    return a[ACC_W-1];
  endfunction

  function automatic ctx_t fn_restart(input ctx_t c, input logic clr);
    ctx_t r;
    r = c;
    if (clr) begin
      r.pc   = '0;
      r.step = ST_FETCH;
    end
    return r;
  endfunction

endpackage

// File: rtl/pp_ctx_ring.sv
module pp_ctx_ring
  import pp_barrel_pkg::*;
#(
  parameter int N_CTX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  ctx_t tail_i,
  output ctx_t head_o
);

  ctx_t stage [N_CTX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTX; i++) stage[i] <= CTX_RESET;
    end else begin
      for (int i = 0; i < N_CTX-1; i++) stage[i] <= fn_restart(stage[i+1], restart_i);
      stage[N_CTX-1] <= fn_restart(tail_i, restart_i);
    end
  end

  assign head_o = stage[0];

endmodule

// File: rtl/pp_slot_count.sv
module pp_slot_count #(
  parameter  int N_CTX  = 10,
  localparam int SLOT_W = $clog2(N_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o
);

  logic [SLOT_W-1:0] slot_d;

  generate
    if ((1 << SLOT_W) == N_CTX) begin : g_pow2
      assign slot_d = slot_o + 1'b1;
    end else begin : g_mod
      assign slot_d = (slot_o == SLOT_W'(N_CTX-1)) ? '0 : slot_o + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_o <= '0;
    else        slot_o <= slot_d;
  end

endmodule

// File: rtl/pp_exec_unit.sv
module pp_exec_unit
  import pp_barrel_pkg::*;
(
  input  ctx_t              cur_i,
  input  logic [WORD_W-1:0] rdata_i,
  output ctx_t              nxt_o,
  output logic              req_o,
  output logic              we_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              ev_fetch_o,
  output logic              ev_branch_o,
  output logic              ev_retire_o
);

  logic [OPC_W-1:0] op;
  logic [FLD_W-1:0] fld;

  assign op  = fn_opcode(rdata_i);
  assign fld = fn_field(rdata_i);

  always_comb begin
    nxt_o       = cur_i;
    req_o       = 1'b0;
    we_o        = 1'b0;
    addr_o      = cur_i.pc;
    wdata_o     = '0;
    ev_fetch_o  = 1'b0;
    ev_branch_o = 1'b0;
    ev_retire_o = 1'b0;

    if (cur_i.step == ST_FETCH) begin
      req_o      = 1'b1;
      ev_fetch_o = 1'b1;
      nxt_o.pc   = cur_i.pc + 1'b1;
      nxt_o.opr  = {{(WORD_W-FLD_W){1'b0}}, fld};
      nxt_o.key  = {1'b0, op};
      case (op)
        OPC_LDN: begin
          nxt_o.acc   = fn_near_const(fld);
          ev_retire_o = 1'b1;
        end
        OPC_LCN: begin
          nxt_o.acc   = fn_comp_const(fld);
          ev_retire_o = 1'b1;
        end
        OPC_MJN, OPC_RAW: begin
          nxt_o.key  = {1'b1, op};
          nxt_o.step = ST_PTR;
        end
        default: ev_retire_o = 1'b1;
      endcase
    end else if (cur_i.key[OPC_W-1:0] == OPC_MJN) begin
      ev_branch_o = 1'b1;
      ev_retire_o = 1'b1;
      nxt_o.step  = ST_FETCH;
      if (fn_is_neg(cur_i.acc)) nxt_o.pc = cur_i.opr;
    end else begin
      req_o  = 1'b1;
      addr_o = cur_i.opr;
      case (cur_i.step)
        ST_PTR: begin
          nxt_o.opr  = rdata_i;
          nxt_o.step = ST_OPND;
        end
        ST_OPND: begin
          nxt_o.acc  = fn_acc_add(cur_i.acc, rdata_i);
          nxt_o.step = ST_WLO;
        end
        ST_WLO: begin
          we_o       = 1'b1;
          wdata_o    = cur_i.acc[WORD_W-1:0];
          nxt_o.step = ST_WHI;
        end
        default: begin
          we_o        = 1'b1;
          addr_o      = cur_i.opr + 1'b1;
          wdata_o     = fn_acc_hi(cur_i.acc);
          nxt_o.step  = ST_FETCH;
          ev_retire_o = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pp_barrel.sv
module pp_barrel
  import pp_barrel_pkg::*;
#(
  parameter  int N_CTX  = 10,
  localparam int SLOT_W = $clog2(N_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deadstart,
  output logic              mem_req,
  output logic              mem_we,
  output logic [SLOT_W-1:0] mem_slot,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  ctx_t              head;
  ctx_t              exec_nxt;
  ctx_t              tail_in;
  logic [SLOT_W-1:0] slot_q;
  logic [STEP_W-1:0] head_step;
  logic              exe_req;
  logic              exe_we;
  logic              ev_fetch;
  logic              ev_branch;
  logic              ev_retire;

  pp_ctx_ring #(.N_CTX(N_CTX)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (deadstart),
    .tail_i    (tail_in),
    .head_o    (head)
  );

  pp_slot_count #(.N_CTX(N_CTX)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_o (slot_q)
  );

  pp_exec_unit u_exec (
    .cur_i       (head),
    .rdata_i     (mem_rdata),
    .nxt_o       (exec_nxt),
    .req_o       (exe_req),
    .we_o        (exe_we),
    .addr_o      (mem_addr),
    .wdata_o     (mem_wdata),
    .ev_fetch_o  (ev_fetch),
    .ev_branch_o (ev_branch),
    .ev_retire_o (ev_retire)
  );

  assign tail_in   = deadstart ? head : exec_nxt;
  assign head_step = head.step;
  assign mem_req   = exe_req & ~deadstart;
  assign mem_we    = exe_we & ~deadstart;
  assign mem_slot  = slot_q;

endmodule

// File: rtl/pp_barrel_chk.sv
module pp_barrel_chk
  import pp_barrel_pkg::*;
#(
  parameter  int N_CTX  = 10,
  localparam int SLOT_W = $clog2(N_CTX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              deadstart,
  input logic              mem_req,
  input logic              mem_we,
  input logic [SLOT_W-1:0] mem_slot,
  input logic [WORD_W-1:0] mem_addr,
  input logic [STEP_W-1:0] head_step,
  input logic              ev_branch,
  input logic              ev_fetch
);

  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mem_slot == (($past(mem_slot) == SLOT_W'(N_CTX-1)) ? '0 : $past(mem_slot) + 1'b1)));

  p_write_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_fetch_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fetch && !deadstart) |-> (mem_req && !mem_we));

  p_quiet_deadstart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deadstart |-> !mem_req);

  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!deadstart && $past(deadstart)) |-> (mem_req && !mem_we && mem_addr == '0));

  p_branch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |-> !mem_req);

  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    head_step <= ST_WHI);

endmodule

bind pp_barrel pp_barrel_chk #(.N_CTX(N_CTX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .deadstart (deadstart),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_slot  (mem_slot),
  .mem_addr  (mem_addr),
  .head_step (head_step),
  .ev_branch (ev_branch),
  .ev_fetch  (ev_fetch)
);

// File: tb/pp_barrel_tb.sv
`timescale 1ns/1ps
module pp_barrel_tb;

  localparam int NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        deadstart = 1'b0;
  logic        mem_req, mem_we;
  logic [3:0]  mem_slot;
  logic [11:0] mem_addr, mem_wdata, mem_rdata;
  logic [11:0] mem [NS][64];

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pp_barrel u_dut (
    .clk(clk), .rst_n(rst_n), .deadstart(deadstart),
    .mem_req(mem_req), .mem_we(mem_we), .mem_slot(mem_slot),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_slot][mem_addr[5:0]];
  always @(posedge clk) if (mem_we) mem[mem_slot][mem_addr[5:0]] <= mem_wdata;

  function automatic logic [11:0] iw(input logic [5:0] op, input logic [5:0] d);
    return {op, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    deadstart = 1'b0;
    for (int s = 0; s < NS; s++) for (int a = 0; a < 64; a++) mem[s][a] = '0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic load_add(input int s);
    mem[s][0]  = iw(6'o14, 6'(s+1));
    mem[s][1]  = iw(6'o56, 6'd40);
    mem[s][2]  = iw(6'o15, 6'd0);
    mem[s][3]  = iw(6'o07, 6'd3);
    mem[s][40] = 12'd50;
    mem[s][50] = 12'(100*s + 7);
  endtask

  task automatic load_branch(input int s);
    mem[s][0]  = iw(6'o14, 6'd1);
    mem[s][1]  = iw(6'o07, 6'd10);
    mem[s][2]  = iw(6'o15, 6'd0);
    mem[s][3]  = iw(6'o07, 6'd12);
    mem[s][4]  = iw(6'o56, 6'd42);
    mem[s][10] = iw(6'o56, 6'd42);
    mem[s][12] = iw(6'o00, 6'd0);
    mem[s][13] = iw(6'o14, 6'd2);
    mem[s][14] = iw(6'o56, 6'd41);
    mem[s][15] = iw(6'o15, 6'd0);
    mem[s][16] = iw(6'o07, 6'd16);
    mem[s][41] = 12'd52;
    mem[s][42] = 12'd54;
    mem[s][52] = 12'(10*s);
  endtask

  task automatic t_reset_state();
    hold_reset();
    for (int s = 0; s < NS; s++) load_add(s);
    release_reset();
    chk(mem_slot == 0, "R1 first slot", int'(mem_slot), 0);
    chk(mem_req && !mem_we && mem_addr == 0, "R1 first fetch addr", int'(mem_addr), 0);
    @(negedge clk); #1;
    chk(mem_slot == 1 && mem_addr == 0, "R2 second slot", int'(mem_slot), 1);
  endtask

  task automatic t_mixed();
    int rot_err = 0;
    int bad_wr = 0;
    hold_reset();
    for (int s = 0; s < NS; s++) if (s % 2 == 0) load_add(s); else load_branch(s);
    release_reset();
    for (int k = 0; k < 300; k++) begin
      if (mem_req && mem_slot != 4'(k % NS)) rot_err++;
      if (mem_we && !(mem_addr inside {12'd50, 12'd51, 12'd52, 12'd53})) bad_wr++;
      if (mem_we && !mem_req) bad_wr++;
      if (k >= 10 && k < 20)
        chk(mem_req && !mem_we && mem_addr == 1, "R4 one-visit load then next word", int'(mem_addr), 1);
      if (k >= 20 && k < 30) begin
        if (k % 2 == 0) chk(mem_req && !mem_we && mem_addr == 40, "R7 pointer read at d", int'(mem_addr), 40);
        else            chk(!mem_req, "R6 branch second visit quiet", int'(mem_req), 0);
      end
      if (k >= 30 && k < 40 && (k % 2 == 1))
        chk(mem_req && mem_addr == 2, "R6 not-taken continues", int'(mem_addr), 2);
      if (k >= 40 && k < 50 && (k % 2 == 0))
        chk(mem_we && mem_addr == 50 && mem_wdata == 12'(100*(k-40) + 7 + (k-40) + 1),
            "R7 low write", int'(mem_wdata), 100*(k-40) + 8 + (k-40));
      @(negedge clk); #1;
    end
    chk(rot_err == 0, "R2 strict rotation", rot_err, 0);
    chk(bad_wr == 0, "R11 writes only in replace-add", bad_wr, 0);
    for (int s = 0; s < NS; s++) begin
      if (s % 2 == 0) begin
        chk(mem[s][50] == 12'(100*s + 8 + s), "R8 per-slot add result", int'(mem[s][50]), 100*s + 8 + s);
        chk(mem[s][51] == 0, "R7 high word", int'(mem[s][51]), 0);
      end else begin
        chk(mem[s][52] == 12'(10*s + 2), "R10 pass then taken branch R6", int'(mem[s][52]), 10*s + 2);
        chk(mem[s][54] == 0, "R6 wrong path not run", int'(mem[s][54]), 0);
      end
    end
  endtask

  task automatic t_carry();
    hold_reset();
    for (int s = 0; s < NS; s++) begin
      mem[s][0]  = iw(6'o15, 6'd0);
      mem[s][1]  = iw(6'o56, 6'd40);
      mem[s][2]  = iw(6'o14, 6'd63);
      mem[s][3]  = iw(6'o56, 6'd41);
      mem[s][4]  = iw(6'o15, 6'd0);
      mem[s][5]  = iw(6'o07, 6'd5);
      mem[s][40] = 12'd50;
      mem[s][41] = 12'd52;
      mem[s][50] = 12'(s + 1);
      mem[s][52] = 12'hFFF;
    end
    release_reset();
    repeat (200) @(negedge clk);
    #1;
    for (int s = 0; s < NS; s++) begin
      chk(mem[s][50] == 12'(s) && mem[s][51] == 0, "R5 complement plus add wraps 18 bits",
          int'(mem[s][50]), s);
      chk(mem[s][52] == 12'h03E && mem[s][53] == 12'd1, "R7 carry into high word",
          int'({mem[s][53], mem[s][52]}), 'h103E);
    end
  endtask

  task automatic t_deadstart();
    hold_reset();
    for (int s = 0; s < NS; s++) load_add(s);
    release_reset();
    repeat (33) @(negedge clk);
    deadstart = 1'b1;
    #1;
    chk(!mem_req, "R9 quiet during deadstart", int'(mem_req), 0);
    @(negedge clk); #1;
    chk(!mem_req && !mem_we, "R9 quiet during deadstart", int'(mem_req), 0);
    @(negedge clk);
    deadstart = 1'b0;
    #1;
    for (int k = 35; k < 45; k++) begin
      chk(mem_req && !mem_we && mem_addr == 0 && mem_slot == 4'(k % NS),
          "R9 restart fetch at zero", int'(mem_addr), 0);
      @(negedge clk); #1;
    end
    repeat (200) @(negedge clk);
    #1;
    for (int s = 0; s < NS; s++)
      chk(mem[s][50] == 12'(100*s + 8 + s), "R9 interrupted add not applied twice",
          int'(mem[s][50]), 100*s + 8 + s);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_mixed();
    t_carry();
    t_deadstart();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule